// File: doc/BRIEF.md
# Bit-Serial Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands using nothing wider than a single full-adder cell and one carry flip-flop. The multiplicand sits in a circular shift register, the multiplier in a right-shifting register, and the growing product in an upper and a lower shift register. For each multiplier bit, the block streams all N bits of the multiplicand through the adder. Each of those bits is gated by the current multiplier bit and summed with the matching bit of the upper register. When the pass ends, one finished product bit drops into the lower register.

A multiply starts with a one-cycle `start` pulse that loads both operands in parallel. The block then runs for exactly N×N cycles, raises `done`, and holds the 2N-bit product until the next accepted start. The controller has three states:
- `ST_IDLE`: after reset.
- `ST_RUN`: the nested loops.
- `ST_DONE`: the result is held.

It has these transitions:
- IDLE→RUN on `start`.
- RUN→DONE when the last inner cycle of the last outer pass completes.
- DONE→RUN on `start`.

In RUN, every cycle asserts the shift-multiplicand, select-sum and shift-upper strobes. The final cycle of each inner pass adds the shift-multiplier and shift-lower strobes and clears the carry. This merges the retire step into the last add, so one product bit is finished every N cycles.

Top module: `serial_mul`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 loads `a_in` and `b_in`; in the next cycle `busy` is 1 and `done` is 0.
- R3: When `done` rises, `product` equals the unsigned product `a_in × b_in` of the loaded operands, in 2N bits with the least significant bit at position 0.
- R4: `done` is 0 for the first N×N−1 clock edges after the accepting start edge and is 1 after edge N×N; `busy` is 1 for exactly N×N cycles and is never high together with `done`.
- R5: While `busy` is 1, `start`, `a_in` and `b_in` are ignored: the run length and the final product are unaffected.
- R6: While `done` is 1 and `start` is 0, `done` stays 1 and `product` does not change, whatever `a_in` and `b_in` do.
- R7: The corner operands 0, 1 and all-ones (2^N−1) in either position give the correct product, including (2^N−1)² where the carry into the top bit is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin a multiply when not busy |
| a_in | input | N | Multiplicand, unsigned |
| b_in | input | N | Multiplier, unsigned |
| busy | output | 1 | High during the N×N working cycles |
| done | output | 1 | High once the product is complete, until the next start |
| product | output | 2N | Unsigned product, upper half first |

## Verification
The assertions assume `start` is a synchronous input that is stable around the clock edge, and that operands only matter on the edge where a start is accepted. They do not assume that `start` stays low during a run. The stimulus changes inputs only on falling edges. During some runs it deliberately pulses `start` and scrambles the operands, so that the ignore rule is exercised rather than assumed. Random operands come from a seeded generator and are mixed with directed 0, 1 and all-ones cases.

// File: rtl/serial_mul_pkg.sv
package serial_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic load;       // parallel load of operands, clear product
        logic shift_a;    // rotate multiplicand one place right
        logic sel_sum;    // adder sum feeds the upper register
        logic shift_hi;   // shift upper register right
        logic shift_b;    // advance to next multiplier bit
        logic shift_lo;   // retire one product bit into lower register
        logic clr_carry;  // clear the carry flip-flop
    } mul_ctl_t;

endpackage

// File: rtl/serial_mul_ctrl.sv
module serial_mul_ctrl
    import serial_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output mul_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    mul_state_e state_q, state_d;
    logic [CW-1:0] inner_q, outer_q;
    logic inner_last, outer_last;

    assign inner_last = (inner_q == LAST);
    assign outer_last = (outer_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // loop counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (ctl.load) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (inner_last) begin
                inner_q <= '0;
                outer_q <= outer_q + 1'b1;
            end else begin
                inner_q <= inner_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (inner_last && outer_last) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl  = '0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.load      = start;
                ctl.clr_carry = start;
            end
            ST_RUN: begin
                busy         = 1'b1;
                ctl.shift_a  = 1'b1;
                ctl.sel_sum  = 1'b1;
                ctl.shift_hi = 1'b1;
                if (inner_last) begin
                    ctl.shift_b   = 1'b1;
                    ctl.shift_lo  = 1'b1;
                    ctl.clr_carry = 1'b1;
                end
            end
            ST_DONE: begin
                done          = 1'b1;
                ctl.load      = start;
                ctl.clr_carry = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/serial_mul_fa.sv
module serial_mul_fa (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    input  logic en,
    input  logic clr,
    output logic sum,
    output logic cout
);
    logic carry_q;

    assign sum  = x ^ y ^ carry_q;
    assign cout = (x & y) | (carry_q & (x ^ y));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (clr) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= cout;
        end
    end

endmodule

// File: rtl/serial_mul_dp.sv
module serial_mul_dp
    import serial_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mul_ctl_t     ctl,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] hi,
    output logic [N-1:0] lo
);
    logic [N-1:0] a_q, b_q, hi_q, lo_q;
    logic gated_a, sum, cout, hi_in;

    assign gated_a = a_q[0] & b_q[0];
    assign hi_in   = ctl.sel_sum ? sum : 1'b0;

    serial_mul_fa u_fa (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (gated_a),
        .y     (hi_q[0]),
        .en    (ctl.sel_sum),
        .clr   (ctl.clr_carry),
        .sum   (sum),
        .cout  (cout)
    );

    // multiplicand: circular, restored after every pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else if (ctl.load) begin
            a_q <= a_in;
        end else if (ctl.shift_a) begin
            a_q <= {a_q[0], a_q[N-1:1]};
        end
    end

    // multiplier: next bit at position 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else if (ctl.load) begin
            b_q <= b_in;
        end else if (ctl.shift_b) begin
            b_q <= {1'b0, b_q[N-1:1]};
        end
    end

    // upper partial product; last cycle of a pass also drops one place
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (ctl.load) begin
            hi_q <= '0;
        end else if (ctl.shift_lo) begin
            hi_q <= {cout, hi_in, hi_q[N-1:2]};
        end else if (ctl.shift_hi) begin
            hi_q <= {hi_in, hi_q[N-1:1]};
        end
    end

    // lower product: one finished bit per pass (lowest sum bit sits at hi_q[1])
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (ctl.load) begin
            lo_q <= '0;
        end else if (ctl.shift_lo) begin
            lo_q <= {hi_q[1], lo_q[N-1:1]};
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/serial_mul.sv
module serial_mul
    import serial_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    mul_ctl_t     ctl;
    logic [N-1:0] hi, lo;

    serial_mul_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    serial_mul_dp #(.N(N)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .a_in  (a_in),
        .b_in  (b_in),
        .hi    (hi),
        .lo    (lo)
    );

    assign product = {hi, lo};

endmodule

// File: rtl/serial_mul_chk.sv
module serial_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 32'd1;
        end
    end

    a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(N * N)));

    a_r4_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

bind serial_mul serial_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/serial_mul_test.sv
module serial_mul_test;
    localparam int N = 8;
    localparam logic [N-1:0] ONES = '1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   a_in = '0;
    logic [N-1:0]   b_in = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    serial_mul #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return (2*N)'(a) * (2*N)'(b);
    endfunction

    task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one multiply; interfere = pulse start and scramble operands mid-run (R5)
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b, input bit interfere, input string tag);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 busy"}, (2*N)'(busy), 1);
        check({tag, " R2 done low"}, (2*N)'(done), 0);
        for (int k = 1; k < N*N; k++) begin
            if (interfere) begin
                start = (k == 5) || (k == N*N/2);
                a_in  = ~a;
                b_in  = N'($urandom);
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        check({tag, " R4 done not early"}, (2*N)'(done), 0);
        check({tag, " R4 busy at last cycle"}, (2*N)'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R4 done on time"}, (2*N)'(done), 1);
        check({tag, " R4 busy low"}, (2*N)'(busy), 0);
        check({tag, interfere ? " R5 product" : " R3 product"}, product, ref_mul(a, b));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", (2*N)'(busy), 0);
        check("R1 done in reset", (2*N)'(done), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 busy after reset", (2*N)'(busy), 0);
        check("R1 done after reset", (2*N)'(done), 0);
        check("R1 product after reset", product, 0);

        // directed corners (R7)
        run_mul('0, '0, 0, "R7 0x0");
        run_mul('0, ONES, 0, "R7 0xff");
        run_mul(ONES, '0, 0, "R7 ffx0");
        run_mul(N'(1), ONES, 0, "R7 1xff");
        run_mul(ONES, N'(1), 0, "R7 ffx1");
        run_mul(ONES, ONES, 0, "R7 ffxff");
        run_mul(N'(1), N'(1), 0, "R7 1x1");

        // hold after done (R6)
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_in = N'($urandom); b_in = N'($urandom);
            check("R6 done held", (2*N)'(done), 1);
            check("R6 product held", product, ref_mul(N'(1), N'(1)));
        end

        // ignore during run (R5)
        run_mul(N'(8'hA5), N'(8'h3C), 1, "R5 a5x3c");
        run_mul(ONES, ONES, 1, "R5 ffxff");

        // random operands (R3)
        for (int k = 0; k < 24; k++) begin
            run_mul(N'($urandom), N'($urandom), (k % 5) == 4, "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule